// File: doc/BRIEF.md
# Shadow Stack Return Unwinder

This block runs the shadow-stack half of an interrupt return. A request hands it the current shadow-stack pointer, the privilege level in force, the target privilege level, the code selector and linear return address being returned to, whether the target runs in 64-bit mode, whether the machine is in long mode, and the user-level shadow-stack pointer register. When the return goes to a privileged level, the block reads a three-record frame from the shadow stack through a read port. It then checks the saved selector and the saved return address against the return state and takes the previous pointer from the third record. When the return goes to user level, the new pointer comes straight from the user register.

A candidate pointer that passes the range check for the target mode leads to the release of the busy token. The release is an atomic compare-exchange request on a separate port, issued only after every check has passed. The sequence ends with a one-cycle `done` pulse that carries the outcome: a control-protection fault, a general-protection fault, or a committed new pointer together with a status bit for a compare-exchange that did not match.

The request, read-request and compare-exchange-request channels use valid/ready. A source holds valid, and the block holds its request fields, until ready is seen high on a rising edge. The block raises `req_ready` only when idle. The read and compare-exchange responses have no ready signal. The block waits for exactly one response per accepted request, and the responder must send exactly one.

Top module: `sstk_ret_unit`

## Requirements
- R1: A request whose pointer has any of bits 2:0 set ends with `cp_fault`. The block issues no read and no compare-exchange.
- R2: For a target level other than 3, the block reads the frame one record at a time, with one request outstanding, in the order pointer+16, pointer+8, pointer+0. Every read address is 8-byte aligned.
- R3: The first record must equal the return selector zero-extended to 64 bits. On a mismatch the sequence ends with `cp_fault` after that single read.
- R4: The second record must equal the 64-bit linear return address. On a mismatch the sequence ends with `cp_fault` after two reads.
- R5: The third record is the candidate pointer. If its bits 1:0 are not zero, the sequence ends with `cp_fault`.
- R6: For target level 3 (binary 11), the candidate pointer is `user_ssp` and the block issues no frame read.
- R7: If the target is not 64-bit and bits 63:32 of the candidate are nonzero, the sequence ends with `gp_fault`.
- R8: If the target is 64-bit, bits 63:47 of the candidate must all be equal. Otherwise the sequence ends with `gp_fault`.
- R9: After all checks pass, the block issues one compare-exchange. Its address is the old pointer: the request pointer plus 24 when the frame was read, and the request pointer itself for target level 3. The expected value is the old pointer with bit 0 set, and the new value is the old pointer with bit 0 clear.
- R10: When long mode is set, the current and target levels are equal, and the candidate equals the old pointer, the block skips the compare-exchange and still commits the candidate.
- R11: After any fault, `new_ssp` keeps its previous value, no compare-exchange is issued, and at most one of `cp_fault` and `gp_fault` is set.
- R12: A compare-exchange answered with `cas_rsp_ok` low raises `tok_fail` with no fault, and the candidate is still committed to `new_ssp`.
- R13: After reset, `req_ready` is 1, `done`, `rd_valid` and `cas_valid` are 0, and `new_ssp` is 0. `done` is a single-cycle pulse. `rd_valid` and `cas_valid` stay high, with their fields unchanged, while ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Return request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_ssp | input | 64 | Current shadow-stack pointer |
| req_cur_pl | input | 2 | Privilege level in force |
| req_tgt_pl | input | 2 | Privilege level returned to |
| req_cs | input | 16 | Code selector returned to |
| req_lip | input | 64 | Code base plus return address |
| req_tgt64 | input | 1 | Target runs in 64-bit mode |
| req_long | input | 1 | Machine is in long mode |
| user_ssp | input | 64 | User-level shadow-stack pointer register |
| rd_valid | output | 1 | Frame read request valid |
| rd_ready | input | 1 | Read port accepts the request |
| rd_addr | output | 64 | Frame record address |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 64 | Read response record |
| cas_valid | output | 1 | Compare-exchange request valid |
| cas_ready | input | 1 | Compare-exchange port accepts the request |
| cas_addr | output | 64 | Token address |
| cas_expect | output | 64 | Expected token value |
| cas_new | output | 64 | Replacement token value |
| cas_rsp_valid | input | 1 | Compare-exchange response valid |
| cas_rsp_ok | input | 1 | Compare-exchange matched and wrote |
| done | output | 1 | One-cycle end-of-sequence pulse |
| new_ssp | output | 64 | Last committed shadow-stack pointer |
| cp_fault | output | 1 | Control-protection fault, valid with done |
| gp_fault | output | 1 | General-protection fault, valid with done |
| tok_fail | output | 1 | Token compare-exchange mismatched, valid with done |

## Verification
The skip of the token release is the hardest outcome to reach. It needs long mode, equal current and target levels, and a third frame record that exactly equals the request pointer plus 24, so the bench plants that record at that address. It then repeats the same frame with long mode cleared to show the release returning. Faults deep in the frame are reached by corrupting one record at a time. In one case the selector record carries a bit above bit 15, which only a true zero-extended compare catches. Back-pressure is applied by toggling both ready inputs, and a repeat of the good path shows the same outcome.

// File: rtl/sstk_ret_pkg.sv
package sstk_ret_pkg;
  // records in one return frame, in read order
  localparam int NREC     = 3;
  localparam int REC_SEL  = 0;
  localparam int REC_LIP  = 1;
  localparam int REC_PREV = 2;

  localparam logic [1:0] PL_USER = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDQ,
    ST_RDW,
    ST_CHK,
    ST_CASQ,
    ST_CASW,
    ST_FIN
  } st_e;
endpackage

// File: rtl/sstk_ret_frame_cmp.sv
module sstk_ret_frame_cmp
  import sstk_ret_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int SEL_W = 16,
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  data,
  input  logic [SEL_W-1:0] ret_cs,
  input  logic [XLEN-1:0]  ret_lip,
  output logic             bad
);
  logic [XLEN-1:0] cs_wide;
  assign cs_wide = {{(XLEN-SEL_W){1'b0}}, ret_cs};

  always_comb begin
    case (int'(idx))
      REC_SEL: bad = (data != cs_wide);
      REC_LIP: bad = (data != ret_lip);
      default: bad = |data[1:0];
    endcase
  end
endmodule

// File: rtl/sstk_ret_ptr_chk.sv
module sstk_ret_ptr_chk #(
  parameter int XLEN    = 64,
  parameter int VA_BITS = 48
) (
  input  logic [XLEN-33:0] hi,
  input  logic             tgt64,
  output logic             bad
);
  logic canon;

  generate
    if (VA_BITS < XLEN) begin : g_canon
      logic [XLEN-VA_BITS:0] top;
      assign top   = hi[XLEN-33:VA_BITS-33];
      assign canon = (&top) | (~|top);
    end else begin : g_full
      assign canon = 1'b1;
    end
  endgenerate

  assign bad = tgt64 ? !canon : (|hi);
endmodule

// File: rtl/sstk_ret_unit.sv
module sstk_ret_unit
  import sstk_ret_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int SEL_W     = 16,
  parameter int VA_BITS   = 48,
  parameter int REC_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [XLEN-1:0]  req_ssp,
  input  logic [1:0]       req_cur_pl,
  input  logic [1:0]       req_tgt_pl,
  input  logic [SEL_W-1:0] req_cs,
  input  logic [XLEN-1:0]  req_lip,
  input  logic             req_tgt64,
  input  logic             req_long,
  input  logic [XLEN-1:0]  user_ssp,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [XLEN-1:0]  rd_addr,
  input  logic             rsp_valid,
  input  logic [XLEN-1:0]  rsp_data,
  output logic             cas_valid,
  input  logic             cas_ready,
  output logic [XLEN-1:0]  cas_addr,
  output logic [XLEN-1:0]  cas_expect,
  output logic [XLEN-1:0]  cas_new,
  input  logic             cas_rsp_valid,
  input  logic             cas_rsp_ok,
  output logic             done,
  output logic [XLEN-1:0]  new_ssp,
  output logic             cp_fault,
  output logic             gp_fault,
  output logic             tok_fail
);
  localparam int IDX_W = $clog2(NREC);
  localparam int FRAME_BYTES = NREC * REC_BYTES;
  localparam logic [XLEN-1:0] FRAME_STEP = XLEN'(FRAME_BYTES);
  localparam logic [XLEN-1:0] REC_STEP   = XLEN'(REC_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(NREC - 1);
  localparam int ALIGN_W = $clog2(REC_BYTES);

  st_e              st_q;
  logic [IDX_W-1:0] idx_q;
  logic [XLEN-1:0]  ssp_q, old_q, cand_q, lip_q, new_q;
  logic [SEL_W-1:0] cs_q;
  logic [1:0]       cur_pl_q, tgt_pl_q;
  logic             t64_q, long_q;
  logic             cp_q, gp_q, tf_q;

  logic             rec_bad, ptr_bad, skip_tok;
  logic [XLEN-1:0]  rd_off;

  sstk_ret_frame_cmp #(
    .XLEN(XLEN), .SEL_W(SEL_W), .IDX_W(IDX_W)
  ) u_frame_cmp (
    .idx(idx_q), .data(rsp_data), .ret_cs(cs_q), .ret_lip(lip_q), .bad(rec_bad)
  );

  sstk_ret_ptr_chk #(
    .XLEN(XLEN), .VA_BITS(VA_BITS)
  ) u_ptr_chk (
    .hi(cand_q[XLEN-1:32]), .tgt64(t64_q), .bad(ptr_bad)
  );

  // records are fetched from the highest address downwards
  assign rd_off   = (XLEN'(NREC - 1) - XLEN'(idx_q)) * REC_STEP;
  assign skip_tok = long_q && (cur_pl_q == tgt_pl_q) && (cand_q == old_q);

  assign req_ready  = (st_q == ST_IDLE);
  assign rd_valid   = (st_q == ST_RDQ);
  assign rd_addr    = ssp_q + rd_off;
  assign cas_valid  = (st_q == ST_CASQ);
  assign cas_addr   = old_q;
  assign cas_expect = old_q | XLEN'(1);
  assign cas_new    = old_q & ~XLEN'(1);
  assign done       = (st_q == ST_FIN);
  assign new_ssp    = new_q;
  assign cp_fault   = cp_q;
  assign gp_fault   = gp_q;
  assign tok_fail   = tf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      ssp_q    <= '0;
      old_q    <= '0;
      cand_q   <= '0;
      lip_q    <= '0;
      new_q    <= '0;
      cs_q     <= '0;
      cur_pl_q <= '0;
      tgt_pl_q <= '0;
      t64_q    <= 1'b0;
      long_q   <= 1'b0;
      cp_q     <= 1'b0;
      gp_q     <= 1'b0;
      tf_q     <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            ssp_q    <= req_ssp;
            cs_q     <= req_cs;
            lip_q    <= req_lip;
            cur_pl_q <= req_cur_pl;
            tgt_pl_q <= req_tgt_pl;
            t64_q    <= req_tgt64;
            long_q   <= req_long;
            idx_q    <= '0;
            cp_q     <= 1'b0;
            gp_q     <= 1'b0;
            tf_q     <= 1'b0;
            if (|req_ssp[ALIGN_W-1:0]) begin
              cp_q <= 1'b1;
              st_q <= ST_FIN;
            end else if (req_tgt_pl == PL_USER) begin
              cand_q <= user_ssp;
              old_q  <= req_ssp;
              st_q   <= ST_CHK;
            end else begin
              old_q <= req_ssp + FRAME_STEP;
              st_q  <= ST_RDQ;
            end
          end
        end
        ST_RDQ: begin
          if (rd_ready) st_q <= ST_RDW;
        end
        ST_RDW: begin
          if (rsp_valid) begin
            if (rec_bad) begin
              cp_q <= 1'b1;
              st_q <= ST_FIN;
            end else if (idx_q == IDX_LAST) begin
              cand_q <= rsp_data;
              st_q   <= ST_CHK;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
              st_q  <= ST_RDQ;
            end
          end
        end
        ST_CHK: begin
          if (ptr_bad) begin
            gp_q <= 1'b1;
            st_q <= ST_FIN;
          end else if (skip_tok) begin
            new_q <= cand_q;
            st_q  <= ST_FIN;
          end else begin
            st_q <= ST_CASQ;
          end
        end
        ST_CASQ: begin
          if (cas_ready) st_q <= ST_CASW;
        end
        ST_CASW: begin
          if (cas_rsp_valid) begin
            tf_q  <= !cas_rsp_ok;
            new_q <= cand_q;
            st_q  <= ST_FIN;
          end
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sstk_ret_unit_chk.sv
module sstk_ret_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic [XLEN-1:0] rd_addr,
  input logic            cas_valid,
  input logic            cas_ready,
  input logic [XLEN-1:0] cas_addr,
  input logic [XLEN-1:0] cas_expect,
  input logic [XLEN-1:0] cas_new,
  input logic            done,
  input logic [XLEN-1:0] new_ssp,
  input logic            cp_fault,
  input logic            gp_fault
);
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R13
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  // R13
  cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_valid && !cas_ready |=> cas_valid && $stable(cas_addr) && $stable(cas_expect));

  // R9
  tok_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cas_valid |-> cas_expect[0] && !cas_new[0] && (cas_expect[XLEN-1:1] == cas_new[XLEN-1:1])
                  && (cas_new == cas_addr));

  // R2
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_addr[2:0] == 3'b000);

  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (cp_fault || gp_fault) |-> new_ssp == $past(new_ssp));

  // R11
  one_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({cp_fault, gp_fault}) <= 1);

  // R13
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({req_ready, rd_valid, cas_valid, done}) <= 1);
endmodule

bind sstk_ret_unit sstk_ret_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .cas_valid(cas_valid), .cas_ready(cas_ready), .cas_addr(cas_addr),
  .cas_expect(cas_expect), .cas_new(cas_new),
  .done(done), .new_ssp(new_ssp), .cp_fault(cp_fault), .gp_fault(gp_fault)
);

// File: tb/sstk_ret_unit_bench.sv
module sstk_ret_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_ssp = '0;
  logic [1:0]  req_cur_pl = '0;
  logic [1:0]  req_tgt_pl = '0;
  logic [15:0] req_cs = '0;
  logic [63:0] req_lip = '0;
  logic        req_tgt64 = 1'b0;
  logic        req_long = 1'b0;
  logic [63:0] user_ssp = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [63:0] rd_addr;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        cas_valid;
  logic        cas_ready = 1'b1;
  logic [63:0] cas_addr, cas_expect, cas_new;
  logic        cas_rsp_valid;
  logic        cas_rsp_ok;
  logic        done;
  logic [63:0] new_ssp;
  logic        cp_fault, gp_fault, tok_fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  sstk_ret_unit u_sstk_ret_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ssp(req_ssp), .req_cur_pl(req_cur_pl), .req_tgt_pl(req_tgt_pl),
    .req_cs(req_cs), .req_lip(req_lip), .req_tgt64(req_tgt64), .req_long(req_long),
    .user_ssp(user_ssp), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cas_valid(cas_valid),
    .cas_ready(cas_ready), .cas_addr(cas_addr), .cas_expect(cas_expect),
    .cas_new(cas_new), .cas_rsp_valid(cas_rsp_valid), .cas_rsp_ok(cas_rsp_ok),
    .done(done), .new_ssp(new_ssp), .cp_fault(cp_fault), .gp_fault(gp_fault),
    .tok_fail(tok_fail)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---- memory and token model ----
  logic [63:0] m_base = '0, m_cs = '0, m_lip = '0, m_prev = '0, m_tok = '0;
  bit bp = 1'b0;
  int cyc = 0;

  function automatic logic [63:0] lookup(input logic [63:0] a);
    if (a == m_base + 64'd16) return m_cs;
    if (a == m_base + 64'd8)  return m_lip;
    if (a == m_base)          return m_prev;
    return 64'hDEAD_BEEF_DEAD_BEEF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_data      <= '0;
      cas_rsp_valid <= 1'b0;
      cas_rsp_ok    <= 1'b0;
    end else begin
      rsp_valid     <= rd_valid && rd_ready;
      rsp_data      <= lookup(rd_addr);
      cas_rsp_valid <= cas_valid && cas_ready;
      cas_rsp_ok    <= (m_tok == cas_expect);
    end
  end

  always @(negedge clk) begin
    cyc++;
    rd_ready  = !bp || cyc[0];
    cas_ready = !bp || cyc[1];
  end

  // ---- scoreboard ----
  typedef struct {
    string       tag;
    bit          cp, gp, tf, cas;
    logic [63:0] nssp, base, caddr;
    int          nrd;
  } exp_t;
  exp_t sb[$];
  logic [63:0] shadow = '0;

  int nrd_seen = 0, ncas_seen = 0;
  logic [63:0] ca_seen = '0, ce_seen = '0, cn_seen = '0;

  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      if (rd_valid && rd_ready) begin
        // R2 read order +16, +8, +0
        chk(rd_addr == sb[0].base + 64'(16 - 8*nrd_seen), "R2", "read address",
            rd_addr, sb[0].base + 64'(16 - 8*nrd_seen));
        nrd_seen++;
      end
      if (cas_valid && cas_ready) begin
        ncas_seen++;
        ca_seen = cas_addr; ce_seen = cas_expect; cn_seen = cas_new;
      end
      if (done) begin
        exp_t e;
        e = sb.pop_front();
        chk(cp_fault == e.cp, e.tag, "cp_fault", 64'(cp_fault), 64'(e.cp));
        chk(gp_fault == e.gp, e.tag, "gp_fault", 64'(gp_fault), 64'(e.gp));
        chk(new_ssp == e.nssp, e.tag, "new_ssp", new_ssp, e.nssp);
        chk(nrd_seen == e.nrd, e.tag, "read count", 64'(nrd_seen), 64'(e.nrd));
        chk(ncas_seen == int'(e.cas), e.tag, "cas count", 64'(ncas_seen), 64'(e.cas));
        if (!e.cp && !e.gp)
          chk(tok_fail == e.tf, e.tag, "tok_fail", 64'(tok_fail), 64'(e.tf));
        if (e.cas && ncas_seen == 1) begin
          // R9 token address and values
          chk(ca_seen == e.caddr, e.tag, "cas_addr", ca_seen, e.caddr);
          chk(ce_seen == (e.caddr | 64'd1), e.tag, "cas_expect", ce_seen, e.caddr | 64'd1);
          chk(cn_seen == (e.caddr & ~64'd1), e.tag, "cas_new", cn_seen, e.caddr & ~64'd1);
        end
        nrd_seen = 0;
        ncas_seen = 0;
      end
    end
  end

  task automatic setmem(input logic [63:0] base, input logic [63:0] cs,
                        input logic [63:0] lip, input logic [63:0] prev,
                        input logic [63:0] tok);
    m_base = base; m_cs = cs; m_lip = lip; m_prev = prev; m_tok = tok;
  endtask

  task automatic run(input string tag, input logic [63:0] ssp, input logic [1:0] cpl,
                     input logic [1:0] tpl, input logic [15:0] cs, input logic [63:0] lip,
                     input bit t64, input bit lng, input logic [63:0] usr,
                     input bit ecp, input bit egp, input bit etf,
                     input logic [63:0] enew, input int enrd, input bit ecas);
    exp_t e;
    e.tag = tag; e.cp = ecp; e.gp = egp; e.tf = etf; e.cas = ecas;
    e.nrd = enrd; e.base = ssp;
    e.caddr = (tpl == 2'd3) ? ssp : ssp + 64'd24;
    if (!(ecp || egp)) shadow = enew;
    e.nssp = shadow;
    @(negedge clk);
    sb.push_back(e);
    req_ssp = ssp; req_cur_pl = cpl; req_tgt_pl = tpl; req_cs = cs; req_lip = lip;
    req_tgt64 = t64; req_long = lng; user_ssp = usr;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  localparam logic [63:0] LIP = 64'h0000_7FFF_0000_1234;

  initial begin
    fork
      begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R13 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(req_ready && !done && !rd_valid && !cas_valid, "R13", "idle outputs after reset",
        {60'd0, req_ready, done, rd_valid, cas_valid}, 64'h8);
    chk(new_ssp == 64'd0, "R13", "new_ssp after reset", new_ssp, 64'd0);

    // R1 misaligned current pointer
    setmem(64'h1000, 64'h9, LIP, 64'h2000, 64'h1019);
    run("R1", 64'h1004, 2'd0, 2'd1, 16'h9, LIP, 1, 1, '0, 1, 0, 0, '0, 0, 0);
    // R2 R9 good privileged return
    run("R9", 64'h1000, 2'd0, 2'd1, 16'h9, LIP, 1, 1, '0, 0, 0, 0, 64'h2000, 3, 1);
    // R3 selector record has a bit above the selector width
    setmem(64'h1000, 64'h1_0000_0009, LIP, 64'h2000, 64'h1019);
    run("R3", 64'h1000, 2'd0, 2'd1, 16'h9, LIP, 1, 1, '0, 1, 0, 0, '0, 1, 0);
    // R4 return address mismatch
    setmem(64'h1000, 64'h9, LIP ^ 64'h10, 64'h2000, 64'h1019);
    run("R4", 64'h1000, 2'd0, 2'd1, 16'h9, LIP, 1, 1, '0, 1, 0, 0, '0, 2, 0);
    // R5 previous pointer not 4-byte aligned
    setmem(64'h1000, 64'h9, LIP, 64'h2002, 64'h1019);
    run("R5", 64'h1000, 2'd0, 2'd1, 16'h9, LIP, 1, 1, '0, 1, 0, 0, '0, 3, 0);
    // R7 narrow target, upper half set
    setmem(64'h1000, 64'h9, LIP, 64'h1_0000_2000, 64'h1019);
    run("R7", 64'h1000, 2'd0, 2'd1, 16'h9, LIP, 0, 1, '0, 0, 1, 0, '0, 3, 0);
    // R7 narrow target, top of 4 GiB is fine
    setmem(64'h1000, 64'h9, LIP, 64'hFFFF_F000, 64'h1019);
    run("R7", 64'h1000, 2'd0, 2'd1, 16'h9, LIP, 0, 1, '0, 0, 0, 0, 64'hFFFF_F000, 3, 1);
    // R8 non-canonical for 64-bit target
    setmem(64'h1000, 64'h9, LIP, 64'h0000_8000_0000_0000, 64'h1019);
    run("R8", 64'h1000, 2'd0, 2'd1, 16'h9, LIP, 1, 1, '0, 0, 1, 0, '0, 3, 0);
    // R8 canonical upper half
    setmem(64'h1000, 64'h9, LIP, 64'hFFFF_8000_0000_0040, 64'h1019);
    run("R8", 64'h1000, 2'd0, 2'd1, 16'h9, LIP, 1, 1, '0, 0, 0, 0, 64'hFFFF_8000_0000_0040, 3, 1);
    // R6 user-level target uses the register, token at the current pointer
    setmem(64'h3000, 64'h9, LIP, 64'h2000, 64'h3001);
    run("R6", 64'h3000, 2'd0, 2'd3, 16'h9, LIP, 1, 1, 64'h0000_7000_0000_0008,
        0, 0, 0, 64'h0000_7000_0000_0008, 0, 1);
    // R6 R8 user-level register non-canonical
    run("R6", 64'h3000, 2'd0, 2'd3, 16'h9, LIP, 1, 1, 64'h0001_0000_0000_0000,
        0, 1, 0, '0, 0, 0);
    // R10 same level, long mode, restored equals old pointer: release skipped
    setmem(64'h1000, 64'h9, LIP, 64'h1018, 64'h1019);
    run("R10", 64'h1000, 2'd0, 2'd0, 16'h9, LIP, 1, 1, '0, 0, 0, 0, 64'h1018, 3, 0);
    // R10 same frame outside long mode: release issued
    run("R10", 64'h1000, 2'd0, 2'd0, 16'h9, LIP, 0, 0, '0, 0, 0, 0, 64'h1018, 3, 1);
    // R12 token mismatch
    setmem(64'h1000, 64'h9, LIP, 64'h2000, 64'h0);
    run("R12", 64'h1000, 2'd0, 2'd1, 16'h9, LIP, 1, 1, '0, 0, 0, 1, 64'h2000, 3, 1);
    // R11 fault after a commit keeps the pointer
    setmem(64'h1000, 64'h7, LIP, 64'h2400, 64'h1019);
    run("R11", 64'h1000, 2'd0, 2'd1, 16'h9, LIP, 1, 1, '0, 1, 0, 0, '0, 1, 0);
    // R13 back-pressure on both request channels
    bp = 1'b1;
    setmem(64'h5000, 64'h9, LIP, 64'h2400, 64'h5019);
    run("R13", 64'h5000, 2'd0, 2'd1, 16'h9, LIP, 1, 1, '0, 0, 0, 0, 64'h2400, 3, 1);
    bp = 1'b0;

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule